// File: doc/BRIEF.md
# Split-Access 64-bit Counter Bank

This block holds a set of 64-bit event counters and one 64-bit control register behind a 32-bit register port. Every 64-bit register occupies two consecutive word addresses. The upper half sits at the lower word, and the lower half sits at the higher word. Software writes and reads whole 64-bit values in two bus cycles without tearing. A write to the upper word is only held in a staging register. The write to the lower word then updates the register with the staged upper half and the new lower half. A read of the upper word freezes a copy of the lower half, so the following lower-word read belongs to the same 64-bit value.

Three request counters add one per cycle while their enable input is high. Four byte counters add a 16-bit byte amount per cycle while their enable input is high. In slot order the counters are:

- requests dequeued
- outbound encrypt requests
- inbound decrypt requests
- outbound bytes encrypted
- outbound bytes protected
- inbound bytes decrypted
- inbound bytes validated

The control register follows the last counter. Bit 31 of its low word is a self-clearing command that zeroes every counter.

Two small state machines run the bus side. The write-stage machine has two states. In `WS_EMPTY` no upper half is staged. In `WS_STAGED` an upper half is held. A mapped upper-word write moves the machine from either state to `WS_STAGED`. A mapped lower-word write commits the register and moves the machine to `WS_EMPTY`. The read-snapshot machine also has two states. In `RS_IDLE` no lower half is frozen. In `RS_HELD` a lower half and its slot number are frozen. A mapped upper-word read enters or re-enters `RS_HELD`. Any lower-word read, or a read of an unmapped address, returns the machine to `RS_IDLE`.

Top module: `split_counter_bank`

## Requirements
- R1: Slot k occupies byte offsets 8k and 8k+4. The word at 8k carries bits 63..32 and the word at 8k+4 carries bits 31..0. The word address is the byte offset divided by four. Slots 0..6 hold the counters in the order listed above, and slot 7 (0x38/0x3C) holds the control register.
- R2: A write to an upper word only stages the data. The target register keeps its value until a lower-word write commits it.
- R3: A lower-word write loads the register with {staged upper half, written data}. The staged half is zero after reset and returns to zero after every commit, so a lone lower-word write leaves bits 63..32 at zero.
- R4: A committed control value with bit 31 set clears all counters at the same clock edge. Bit 31 always reads back as 0, and all other control bits read back as written.
- R5: Each request counter adds exactly 1 on every clock edge at which its enable is high.
- R6: Each byte counter adds its 16-bit byte amount, zero-extended, on every clock edge at which its enable is high. Carries propagate across bit 32.
- R7: When a commit write and an increment hit the same counter on the same edge, the written value is stored and the increment is lost.
- R8: A mapped upper-word read freezes the lower 32 bits of that register. The next lower-word read of the same slot returns the frozen bits even if the counter has moved since, and it releases the freeze. A lower-word read with no freeze held returns the live value.
- R9: Reads of slots 8 and above return zero. Writes to them change no register and stage nothing.
- R10: Read data and `rd_valid` appear one clock after `rd_en` is sampled.
- R11: After reset, all counters, the control register and the staging register are zero, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | WADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_word | input | WADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data valid |
| req_inc | input | NUM_REQ | Per-request-counter increment enables |
| byte_inc | input | NUM_BYTE | Per-byte-counter add enables |
| byte_cnt | input | NUM_BYTE*BCNT_W | Packed byte amounts, counter j at bits j*BCNT_W upward |

## Verification
The bench builds the block with its default parameters: three request counters, four byte counters, 16-bit byte amounts and a 6-bit word address. With these values the eight mapped slots fill only a quarter of the 32 addressable slots, so reads and writes of unmapped slots can be tested. The 64-bit width allows counters to be preset just below a 32-bit carry, so the tests can show a frozen lower half while the live value has already carried into the upper word. The 16-bit byte amount lets the largest amount, 0xFFFF, be added on back-to-back cycles.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
    localparam int WORD_W = 32;
    localparam int REG_W  = 64;

    typedef enum logic {
        WS_EMPTY,
        WS_STAGED
    } wstage_e;

    typedef enum logic {
        RS_IDLE,
        RS_HELD
    } rsnap_e;
endpackage

// File: rtl/cbank_counter.sv
module cbank_counter #(
    parameter int BCNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        wr_i,
    input  logic [cbank_pkg::REG_W-1:0] wdata_i,
    input  logic                        inc_i,
    input  logic [BCNT_W-1:0]           amount_i,
    output logic [cbank_pkg::REG_W-1:0] cnt_o
);
    import cbank_pkg::*;

    logic [REG_W-1:0] step;
    logic [REG_W-1:0] cnt_q;

    assign step  = {{(REG_W-BCNT_W){1'b0}}, amount_i};
    assign cnt_o = cnt_q;

    // clear beats write, write beats increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (wr_i)
            cnt_q <= wdata_i;
        else if (inc_i)
            cnt_q <= cnt_q + step;
    end

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> cnt_q == $past(wdata_i)); // R7
    AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && !clr_i) |=> cnt_q == $past(cnt_q) + {{(REG_W-BCNT_W){1'b0}}, $past(amount_i)}); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i && !clr_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/cbank_wr_stage.sv
module cbank_wr_stage #(
    parameter int WADDR_W  = 6,
    parameter int NUM_SLOT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [WADDR_W-1:0]            wr_word_i,
    input  logic [cbank_pkg::WORD_W-1:0]  wr_data_i,
    output logic                          commit_o,
    output logic [WADDR_W-2:0]            commit_slot_o,
    output logic [cbank_pkg::REG_W-1:0]   commit_data_o
);
    import cbank_pkg::*;

    localparam int SLOT_W = WADDR_W - 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

    wstage_e            state_q, state_d;
    logic [WORD_W-1:0]  staged_q;
    logic [SLOT_W-1:0]  slot;
    logic               mapped, stage_hit, commit_hit;

    assign slot       = wr_word_i[WADDR_W-1:1];
    assign mapped     = (slot <= LAST_SLOT);
    assign stage_hit  = wr_en_i && mapped && !wr_word_i[0];
    assign commit_hit = wr_en_i && mapped &&  wr_word_i[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_EMPTY:  if (stage_hit) state_d = WS_STAGED;
            WS_STAGED: if (commit_hit) state_d = WS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WS_EMPTY;
            staged_q <= '0;
        end else begin
            state_q <= state_d;
            if (stage_hit)
                staged_q <= wr_data_i;
            else if (commit_hit)
                staged_q <= '0;
        end
    end

    always_comb begin
        commit_o      = commit_hit;
        commit_slot_o = slot;
        commit_data_o = {(state_q == WS_STAGED) ? staged_q : {WORD_W{1'b0}}, wr_data_i};
    end

    AST_STAGE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_hit |=> (state_q == WS_EMPTY && staged_q == '0)); // R3
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(staged_q)); // R2
    AST_UNMAPPED_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !mapped) |=> $stable(staged_q)); // R9
endmodule

// File: rtl/cbank_rd_snap.sv
module cbank_rd_snap #(
    parameter int WADDR_W  = 6,
    parameter int NUM_SLOT = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        rd_en_i,
    input  logic [WADDR_W-1:0]                          rd_word_i,
    input  logic [NUM_SLOT-1:0][cbank_pkg::REG_W-1:0]   vals_i,
    output logic [cbank_pkg::WORD_W-1:0]                rd_data_o,
    output logic                                        rd_valid_o
);
    import cbank_pkg::*;

    localparam int SLOT_W = WADDR_W - 1;
    localparam int IDX_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

    rsnap_e             state_q, state_d;
    logic [SLOT_W-1:0]  held_slot_q;
    logic [WORD_W-1:0]  held_lo_q;
    logic [SLOT_W-1:0]  slot;
    logic [IDX_W-1:0]   idx;
    logic               is_lo, mapped, hit;
    logic [REG_W-1:0]   live;

    assign slot   = rd_word_i[WADDR_W-1:1];
    assign is_lo  = rd_word_i[0];
    assign mapped = (slot <= LAST_SLOT);
    assign idx    = IDX_W'(slot);
    assign live   = mapped ? vals_i[idx] : '0;
    assign hit    = (state_q == RS_HELD) && (held_slot_q == slot);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (rd_en_i && mapped && !is_lo) state_d = RS_HELD;
            RS_HELD: if (rd_en_i && (is_lo || !mapped)) state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= RS_IDLE;
            held_slot_q <= '0;
            held_lo_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en_i && mapped && !is_lo) begin
                held_slot_q <= slot;
                held_lo_q   <= live[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                if (!mapped)
                    rd_data_o <= '0;
                else if (is_lo)
                    rd_data_o <= hit ? held_lo_q : live[WORD_W-1:0];
                else
                    rd_data_o <= live[REG_W-1:WORD_W];
            end
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !mapped) |=> rd_data_o == '0); // R9
    AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && is_lo && hit) |=> rd_data_o == $past(held_lo_q)); // R8
    AST_SNAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && is_lo) |=> state_q == RS_IDLE); // R8
endmodule

// File: rtl/split_counter_bank.sv
module split_counter_bank #(
    parameter int NUM_REQ  = 3,
    parameter int NUM_BYTE = 4,
    parameter int BCNT_W   = 16,
    parameter int WADDR_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WADDR_W-1:0]         wr_word,
    input  logic [31:0]                wr_data,
    input  logic                       rd_en,
    input  logic [WADDR_W-1:0]         rd_word,
    output logic [31:0]                rd_data,
    output logic                       rd_valid,
    input  logic [NUM_REQ-1:0]         req_inc,
    input  logic [NUM_BYTE-1:0]        byte_inc,
    input  logic [NUM_BYTE*BCNT_W-1:0] byte_cnt
);
    import cbank_pkg::*;

    localparam int NUM_CNT   = NUM_REQ + NUM_BYTE;
    localparam int CTRL_SLOT = NUM_CNT;
    localparam int NUM_SLOT  = NUM_CNT + 1;
    localparam int SLOT_W    = WADDR_W - 1;
    localparam int CLR_BIT   = 31;

    logic                           commit;
    logic [SLOT_W-1:0]              commit_slot;
    logic [REG_W-1:0]               commit_data;
    logic                           soft_clr;
    logic [REG_W-1:0]               ctrl_q;
    logic [NUM_SLOT-1:0][REG_W-1:0] vals;

    cbank_wr_stage #(.WADDR_W(WADDR_W), .NUM_SLOT(NUM_SLOT)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_word_i     (wr_word),
        .wr_data_i     (wr_data),
        .commit_o      (commit),
        .commit_slot_o (commit_slot),
        .commit_data_o (commit_data)
    );

    assign soft_clr = commit && (commit_slot == SLOT_W'(CTRL_SLOT)) && commit_data[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (commit && commit_slot == SLOT_W'(CTRL_SLOT))
            ctrl_q <= commit_data & ~(REG_W'(1) << CLR_BIT);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            logic             inc;
            logic [BCNT_W-1:0] amt;
            if (gi < NUM_REQ) begin : g_req
                assign inc = req_inc[gi];
                assign amt = BCNT_W'(1);
            end else begin : g_byte
                assign inc = byte_inc[gi-NUM_REQ];
                assign amt = byte_cnt[(gi-NUM_REQ)*BCNT_W +: BCNT_W];
            end
            cbank_counter #(.BCNT_W(BCNT_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr_i    (soft_clr),
                .wr_i     (commit && commit_slot == SLOT_W'(gi)),
                .wdata_i  (commit_data),
                .inc_i    (inc),
                .amount_i (amt),
                .cnt_o    (vals[gi])
            );
        end
    endgenerate

    assign vals[CTRL_SLOT] = ctrl_q;

    cbank_rd_snap #(.WADDR_W(WADDR_W), .NUM_SLOT(NUM_SLOT)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .rd_word_i  (rd_word),
        .vals_i     (vals),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );

    AST_CTRL_CLR_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (ctrl_q[CLR_BIT] == 1'b0 && vals[0] == '0)); // R4
    AST_REQ_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_inc[0] && !commit) |=> vals[0] == $past(vals[0]) + REG_W'(1)); // R5
endmodule

// File: tb/split_counter_bank_test.sv
module split_counter_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_REQ  = 3;
    localparam int NUM_BYTE = 4;
    localparam int BCNT_W   = 16;
    localparam int WADDR_W  = 6;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       wr_en = 1'b0;
    logic [WADDR_W-1:0]         wr_word = '0;
    logic [31:0]                wr_data = '0;
    logic                       rd_en = 1'b0;
    logic [WADDR_W-1:0]         rd_word = '0;
    logic [31:0]                rd_data;
    logic                       rd_valid;
    logic [NUM_REQ-1:0]         req_inc = '0;
    logic [NUM_BYTE-1:0]        byte_inc = '0;
    logic [NUM_BYTE*BCNT_W-1:0] byte_cnt = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_counter_bank #(.NUM_REQ(NUM_REQ), .NUM_BYTE(NUM_BYTE), .BCNT_W(BCNT_W), .WADDR_W(WADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .rd_en(rd_en), .rd_word(rd_word), .rd_data(rd_data), .rd_valid(rd_valid),
        .req_inc(req_inc), .byte_inc(byte_inc), .byte_cnt(byte_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] boff, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_word = boff[7:2]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] boff, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_word = boff[7:2];
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        chk("R10 rd_valid", {31'd0, rd_valid}, 32'd1);
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] boff, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(boff, d);
        chk(tag, d, exp);
    endtask

    task automatic pulse_req(input logic [NUM_REQ-1:0] m, input int n);
        @(negedge clk);
        req_inc = m;
        repeat (n) @(negedge clk);
        req_inc = '0;
    endtask

    task automatic t_reset_state;
        chk("R11 rd_valid low after reset", {31'd0, rd_valid}, 32'd0);
        expect_rd("R11 slot0 hi", 8'h00, 32'h0);
        expect_rd("R11 slot0 lo", 8'h04, 32'h0);
        expect_rd("R11 ctrl lo", 8'h3C, 32'h0);
    endtask

    task automatic t_stage_then_commit;
        bus_wr(8'h08, 32'h0000AAAA);
        expect_rd("R2 staged hi not visible", 8'h08, 32'h0);
        expect_rd("R2 staged lo not visible", 8'h0C, 32'h0);
        bus_wr(8'h0C, 32'h00000001);
        expect_rd("R1 R3 hi word at lower offset", 8'h08, 32'h0000AAAA);
        expect_rd("R1 R3 lo word at higher offset", 8'h0C, 32'h00000001);
    endtask

    task automatic t_lone_lo_write;
        bus_wr(8'h14, 32'h00000007);
        expect_rd("R3 lone lo write hi zero", 8'h10, 32'h0);
        expect_rd("R3 lone lo write lo", 8'h14, 32'h00000007);
    endtask

    task automatic t_request_counts;
        pulse_req(3'b001, 4);
        expect_rd("R5 slot0 after 4", 8'h04, 32'd4);
        pulse_req(3'b100, 2);
        expect_rd("R5 slot2 after 2 more", 8'h14, 32'd9);
        expect_rd("R5 slot1 untouched", 8'h0C, 32'h00000001);
    endtask

    task automatic t_byte_counts;
        @(negedge clk);
        byte_inc = 4'b0001; byte_cnt = '0; byte_cnt[15:0] = 16'h1234;
        repeat (3) @(negedge clk);
        byte_inc = 4'b1000; byte_cnt = '0; byte_cnt[63:48] = 16'hFFFF;
        repeat (2) @(negedge clk);
        byte_inc = '0;
        expect_rd("R6 slot3 hi", 8'h18, 32'h0);
        expect_rd("R6 slot3 lo", 8'h1C, 32'h0000369C);
        expect_rd("R6 slot6 lo", 8'h34, 32'h0001FFFE);
        expect_rd("R6 slot4 idle", 8'h24, 32'h0);
    endtask

    task automatic t_write_wins;
        @(negedge clk);
        wr_en = 1'b1; wr_word = 6'h01; wr_data = 32'h00000055; req_inc = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; req_inc = '0;
        expect_rd("R7 write beats increment", 8'h04, 32'h00000055);
    endtask

    task automatic t_snapshot;
        bus_wr(8'h00, 32'h00000002);
        bus_wr(8'h04, 32'hFFFFFFFE);
        expect_rd("R8 hi read", 8'h00, 32'h00000002);
        pulse_req(3'b001, 5);
        expect_rd("R8 frozen lo", 8'h04, 32'hFFFFFFFE);
        expect_rd("R8 live lo after release", 8'h04, 32'h00000003);
        expect_rd("R8 carried hi", 8'h00, 32'h00000003);
    endtask

    task automatic t_control;
        bus_wr(8'h38, 32'h12345678);
        bus_wr(8'h3C, 32'h00000005);
        expect_rd("R4 ctrl hi readback", 8'h38, 32'h12345678);
        expect_rd("R4 ctrl lo readback", 8'h3C, 32'h00000005);
        bus_wr(8'h3C, 32'h80000009);
        expect_rd("R4 ctrl bit31 self clears", 8'h3C, 32'h00000009);
        expect_rd("R4 R3 ctrl hi zero after lone write", 8'h38, 32'h0);
        expect_rd("R4 slot0 cleared", 8'h04, 32'h0);
        expect_rd("R4 slot1 hi cleared", 8'h08, 32'h0);
        expect_rd("R4 slot6 cleared", 8'h34, 32'h0);
    endtask

    task automatic t_unmapped;
        bus_wr(8'h40, 32'h0000DEAD);
        expect_rd("R9 unmapped hi reads zero", 8'h40, 32'h0);
        bus_wr(8'h44, 32'h00000077);
        expect_rd("R9 unmapped lo reads zero", 8'h44, 32'h0);
        bus_wr(8'h1C, 32'h00000009);
        expect_rd("R9 unmapped write staged nothing", 8'h18, 32'h0);
        expect_rd("R9 mapped lo still writable", 8'h1C, 32'h00000009);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_stage_then_commit();
        t_lone_lo_write();
        t_request_counts();
        t_byte_counts();
        t_write_wins();
        t_snapshot();
        t_control();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule